// File: doc/BRIEF.md
# Unlock-Protected Command Sequence Decoder

This block sits on the device side of an 8-bit parallel memory bus and watches the write cycles that arrive there. Each write arrives as a single-cycle synchronous strobe that carries an address and a data byte. A command is accepted only after a two-write unlock key has been seen at fixed addresses. Erase commands also need a setup code followed by a second unlock pair.

When a sequence completes, the decoder raises exactly one one-cycle strobe:

- a program strobe, with the target address and byte;
- a sector-erase strobe, with the sector number;
- a chip-erase strobe.

It also keeps an identification-mode flag. While the flag is set, reads are redirected from the array data to a small set of identification bytes.

Any write that breaks the expected step drops the decoder back to read mode. Every write is ignored while the storage engine reports that a program or erase is in progress.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, all three strobes are low and identification mode is off. `rd_data_o` then follows `arr_data_i`. Reset also clears identification mode if it was set.
- R2: A program runs when these four writes arrive in order: AA at 5555, 55 at 2AAA, A0 at 5555, then any address and byte. One cycle after the fourth write, `prog_stb_o` is high for exactly one cycle, and `prog_addr_o`/`prog_data_o` hold that write's full 17-bit address and byte.
- R3: A chip erase runs after these six writes: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, then 10@5555. One cycle after the sixth write, `chip_stb_o` pulses for one cycle.
- R4: A sector erase uses the same five leading writes, with 30 at any address as the sixth. One cycle later, `sect_stb_o` pulses and `sect_num_o` equals bits 16..12 of that address (32 sectors of 4 KB).
- R5: Address bit 16 is not compared on the key and command cycles. Only bits 15..0 must match.
- R6: After the writes AA@5555, 55@2AAA, 90@5555, identification mode is set. In that mode, reads return 7F at address 0, A8 at 1, 7F at 3, 1F at 0x40, and 00 at every other address.
- R7: Identification mode is cleared in either of two ways: the three writes AA@5555, 55@2AAA, F0@5555, or a single write of F0 at any address. The one exception is the data byte of a program's fourth write: F0 there is programmed and does not exit.
- R8: A write that does not match the expected step aborts the sequence. The writes that follow must begin again from the first unlock write.
- R9: A write made while `busy_i` is high has no effect. It produces no strobe, leaves identification mode unchanged, and does not move the sequence position.
- R10: At most one strobe is high in any cycle, and a strobe only ever follows an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | 17 | Write address |
| wr_data_i | input | 8 | Write data |
| busy_i | input | 1 | Program or erase in progress |
| rd_addr_i | input | 17 | Read address |
| arr_data_i | input | 8 | Byte read from the array |
| rd_data_o | output | 8 | Read data after identification redirect |
| id_mode_o | output | 1 | Identification mode active |
| prog_stb_o | output | 1 | Program request pulse |
| prog_addr_o | output | 17 | Program target address |
| prog_data_o | output | 8 | Program byte |
| sect_stb_o | output | 1 | Sector erase request pulse |
| sect_num_o | output | 5 | Sector to erase |
| chip_stb_o | output | 1 | Chip erase request pulse |

## Verification
The busy guard and the completion of a command can meet in the same cycle. The final address-and-data write of a program, or a mid-sequence command byte, can arrive while `busy_i` is high.

The bench provokes this by placing a busy write right after the key pair and again as the fourth program write. It expects no strobe on either. It then expects a normal program strobe from the next non-busy write, which shows that the ignored writes left the sequence position untouched.

// File: rtl/unlock_cmd_pkg.sv
package unlock_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ESET, ST_EKEY1, ST_EKEY2
  } step_e;

  typedef enum logic [1:0] {ACT_NONE, ACT_PROG, ACT_SECT, ACT_CHIP} act_e;

  localparam int unsigned CMP_W = 16;
  localparam logic [CMP_W-1:0] KEY_ADDR_A = 16'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESET   = 8'h80;
  localparam logic [7:0] CMD_ID_IN  = 8'h90;
  localparam logic [7:0] CMD_ID_OUT = 8'hF0;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
endpackage

// File: rtl/unlock_step_fsm.sv
module unlock_step_fsm
  import unlock_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             busy_i,
  input  logic [CMP_W-1:0] cmp_addr_i,
  input  logic [7:0]       wr_data_i,
  output act_e             act_o,
  output logic             id_set_o,
  output logic             id_clr_o
);
  step_e st_q, st_d;
  logic  hit_a, hit_b, take;

  assign hit_a = (cmp_addr_i == KEY_ADDR_A);
  assign hit_b = (cmp_addr_i == KEY_ADDR_B);
  assign take  = wr_en_i && !busy_i;

  always_comb begin
    st_d     = st_q;
    act_o    = ACT_NONE;
    id_set_o = 1'b0;
    id_clr_o = 1'b0;
    if (take) begin
      st_d = ST_IDLE;  // any mismatch falls back to read mode
      case (st_q)
        ST_IDLE:  if (hit_a && wr_data_i == KEY_A) st_d = ST_KEY1;
        ST_KEY1:  if (hit_b && wr_data_i == KEY_B) st_d = ST_KEY2;
        ST_KEY2: begin
          if (hit_a) begin
            case (wr_data_i)
              CMD_PROG:  st_d = ST_PROG;
              CMD_ESET:  st_d = ST_ESET;
              CMD_ID_IN: id_set_o = 1'b1;
              default:   ;
            endcase
          end
        end
        ST_PROG:  act_o = ACT_PROG;
        ST_ESET:  if (hit_a && wr_data_i == KEY_A) st_d = ST_EKEY1;
        ST_EKEY1: if (hit_b && wr_data_i == KEY_B) st_d = ST_EKEY2;
        ST_EKEY2: begin
          if (wr_data_i == CMD_SECT)                act_o = ACT_SECT;
          else if (hit_a && wr_data_i == CMD_CHIP)  act_o = ACT_CHIP;
        end
        default:  ;
      endcase
      // F0 anywhere leaves ID mode, except as program payload
      if (st_q != ST_PROG && wr_data_i == CMD_ID_OUT) id_clr_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/cmd_out_reg.sv
module cmd_out_reg
  import unlock_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SECT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  act_e              act_i,
  input  logic              id_set_i,
  input  logic              id_clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_stb_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              sect_stb_o,
  output logic [SECT_W-1:0] sect_num_o,
  output logic              chip_stb_o,
  output logic              id_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_stb_o  <= 1'b0;
      sect_stb_o  <= 1'b0;
      chip_stb_o  <= 1'b0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
      sect_num_o  <= '0;
      id_mode_o   <= 1'b0;
    end else begin
      prog_stb_o <= (act_i == ACT_PROG);
      sect_stb_o <= (act_i == ACT_SECT);
      chip_stb_o <= (act_i == ACT_CHIP);
      if (act_i == ACT_PROG) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
      end
      if (act_i == ACT_SECT) sect_num_o <= addr_i[ADDR_W-1 -: SECT_W];
      if (id_set_i)      id_mode_o <= 1'b1;
      else if (id_clr_i) id_mode_o <= 1'b0;
    end
  end
endmodule

// File: rtl/id_read_mux.sv
module id_read_mux #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] id_byte;

  always_comb begin
    case (rd_addr_i)
      ADDR_W'(0):    id_byte = DATA_W'(8'h7F);
      ADDR_W'(1):    id_byte = DATA_W'(8'hA8);
      ADDR_W'(3):    id_byte = DATA_W'(8'h7F);
      ADDR_W'(8'h40): id_byte = DATA_W'(8'h1F);
      default:       id_byte = '0;
    endcase
  end

  assign rd_data_o = id_mode_i ? id_byte : arr_data_i;
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import unlock_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SECT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              id_mode_o,
  output logic              prog_stb_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              sect_stb_o,
  output logic [SECT_W-1:0] sect_num_o,
  output logic              chip_stb_o
);
  act_e act;
  logic id_set, id_clr;

  unlock_step_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .busy_i    (busy_i),
    .cmp_addr_i(wr_addr_i[CMP_W-1:0]),
    .wr_data_i (wr_data_i[7:0]),
    .act_o     (act),
    .id_set_o  (id_set),
    .id_clr_o  (id_clr)
  );

  cmd_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .id_set_i   (id_set),
    .id_clr_i   (id_clr),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .prog_stb_o (prog_stb_o),
    .prog_addr_o(prog_addr_o),
    .prog_data_o(prog_data_o),
    .sect_stb_o (sect_stb_o),
    .sect_num_o (sect_num_o),
    .chip_stb_o (chip_stb_o),
    .id_mode_o  (id_mode_o)
  );

  id_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .id_mode_i (id_mode_o),
    .rd_addr_i (rd_addr_i),
    .arr_data_i(arr_data_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/unlock_cmd_checker.sv
module unlock_cmd_checker #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SECT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              busy_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              id_mode_o,
  input logic              prog_stb_o,
  input logic              sect_stb_o,
  input logic [SECT_W-1:0] sect_num_o,
  input logic              chip_stb_o
);
  logic any_stb;
  assign any_stb = prog_stb_o | sect_stb_o | chip_stb_o;

  p_one_stb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_stb_o, sect_stb_o, chip_stb_o}));

  p_stb_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> $past(wr_en_i && !busy_i));

  p_prog_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stb_o |=> !prog_stb_o);

  p_busy_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_i) |=> (!any_stb && $stable(id_mode_o)));

  p_id_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> $past(wr_data_i == DATA_W'(8'h90) && wr_addr_i[15:0] == 16'h5555));

  p_id_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> $past(wr_data_i == DATA_W'(8'hF0)));

  p_id_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_o && rd_addr_i == '0) |-> rd_data_o == DATA_W'(8'h7F));

  p_sect_num_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_stb_o |-> sect_num_o == $past(wr_addr_i[ADDR_W-1 -: SECT_W]));
endmodule

bind unlock_cmd_decoder unlock_cmd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .busy_i    (busy_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .id_mode_o (id_mode_o),
  .prog_stb_o(prog_stb_o),
  .sect_stb_o(sect_stb_o),
  .sect_num_o(sect_num_o),
  .chip_stb_o(chip_stb_o)
);

// File: tb/tb_unlock_cmd_decoder.sv
module tb_unlock_cmd_decoder;
  localparam int CLK_P = 10;
  localparam int NV    = 40;

  // k: 0 none, 1 program, 2 sector erase, 3 chip erase
  typedef struct packed {
    logic [16:0] a;
    logic [7:0]  d;
    logic [1:0]  k;
    logic        idm;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    // R2 program, R5 bit 16 set on key write
    '{17'h15555, 8'hAA, 2'd0, 1'b0, 4'd5},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd2},
    '{17'h05555, 8'hA0, 2'd0, 1'b0, 4'd2},
    '{17'h1ABCD, 8'h3C, 2'd1, 1'b0, 4'd2},
    // R3 chip erase, R5 on fifth write
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd3},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd3},
    '{17'h05555, 8'h80, 2'd0, 1'b0, 4'd3},
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd3},
    '{17'h12AAA, 8'h55, 2'd0, 1'b0, 4'd5},
    '{17'h05555, 8'h10, 2'd3, 1'b0, 4'd3},
    // R4 sector erase, sector 0x17
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd4},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd4},
    '{17'h05555, 8'h80, 2'd0, 1'b0, 4'd4},
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd4},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd4},
    '{17'h17123, 8'h30, 2'd2, 1'b0, 4'd4},
    // R8 bad second key aborts, later writes do nothing
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd8},
    '{17'h02AAA, 8'h56, 2'd0, 1'b0, 4'd8},
    '{17'h05555, 8'hA0, 2'd0, 1'b0, 4'd8},
    '{17'h01234, 8'h77, 2'd0, 1'b0, 4'd8},
    // R6 ID entry
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd6},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd6},
    '{17'h05555, 8'h90, 2'd0, 1'b1, 4'd6},
    // R7 single-write exit at arbitrary address
    '{17'h0ABCD, 8'hF0, 2'd0, 1'b0, 4'd7},
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd6},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd6},
    '{17'h05555, 8'h90, 2'd0, 1'b1, 4'd6},
    // R7 three-write exit
    '{17'h05555, 8'hAA, 2'd0, 1'b1, 4'd7},
    '{17'h02AAA, 8'h55, 2'd0, 1'b1, 4'd7},
    '{17'h05555, 8'hF0, 2'd0, 1'b0, 4'd7},
    // R7 F0 as program payload is programmed
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd7},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd7},
    '{17'h05555, 8'hA0, 2'd0, 1'b0, 4'd7},
    '{17'h00042, 8'hF0, 2'd1, 1'b0, 4'd7},
    // R8 wrong final erase code
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd8},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd8},
    '{17'h05555, 8'h80, 2'd0, 1'b0, 4'd8},
    '{17'h05555, 8'hAA, 2'd0, 1'b0, 4'd8},
    '{17'h02AAA, 8'h55, 2'd0, 1'b0, 4'd8},
    '{17'h05555, 8'h20, 2'd0, 1'b0, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  arr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        id_mode, prog_stb, sect_stb, chip_stb;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;
  logic [4:0]  sect_num;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  unlock_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .rd_addr_i(rd_addr),
    .arr_data_i(arr_data), .rd_data_o(rd_data), .id_mode_o(id_mode),
    .prog_stb_o(prog_stb), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .sect_stb_o(sect_stb), .sect_num_o(sect_num), .chip_stb_o(chip_stb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after the capturing edge
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic b);
    wr_addr = a; wr_data = d; busy = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    arr_data = 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {prog_stb, sect_stb, chip_stb}, 0);
    chk("R1 id_mode", id_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 read passthrough", rd_data, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d, 1'b0);
      chk($sformatf("R%0d v%0d prog_stb", VEC[i].req, i), prog_stb, VEC[i].k == 2'd1);
      chk($sformatf("R%0d v%0d sect_stb", VEC[i].req, i), sect_stb, VEC[i].k == 2'd2);
      chk($sformatf("R%0d v%0d chip_stb", VEC[i].req, i), chip_stb, VEC[i].k == 2'd3);
      chk($sformatf("R%0d v%0d id_mode", VEC[i].req, i), id_mode, VEC[i].idm);
      if (VEC[i].k == 2'd1) begin
        chk($sformatf("R%0d v%0d prog_addr", VEC[i].req, i), prog_addr, VEC[i].a);
        chk($sformatf("R%0d v%0d prog_data", VEC[i].req, i), prog_data, VEC[i].d);
      end
      if (VEC[i].k == 2'd2)
        chk($sformatf("R%0d v%0d sect_num", VEC[i].req, i), sect_num, VEC[i].a[16:12]);
    end
    @(negedge clk);
    chk("R10 strobe dropped", {prog_stb, sect_stb, chip_stb}, 0);

    // R6 ID byte reads
    wr(17'h05555, 8'hAA, 1'b0);
    wr(17'h02AAA, 8'h55, 1'b0);
    wr(17'h05555, 8'h90, 1'b0);
    rd_addr = 17'h00000; #1 chk("R6 id@0", rd_data, 8'h7F);
    rd_addr = 17'h00001; #1 chk("R6 id@1", rd_data, 8'hA8);
    rd_addr = 17'h00003; #1 chk("R6 id@3", rd_data, 8'h7F);
    rd_addr = 17'h00040; #1 chk("R6 id@40", rd_data, 8'h1F);
    rd_addr = 17'h00002; #1 chk("R6 id other", rd_data, 8'h00);

    // R1 reset clears ID mode
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears id", id_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 read back to array", rd_data, 8'h5A);

    // R9 busy writes are ignored and keep position
    wr(17'h05555, 8'hAA, 1'b0);
    wr(17'h02AAA, 8'h55, 1'b0);
    wr(17'h05555, 8'h80, 1'b1);
    chk("R9 busy cmd no strobe", {prog_stb, sect_stb, chip_stb}, 0);
    wr(17'h05555, 8'hA0, 1'b0);
    wr(17'h00010, 8'h11, 1'b1);
    chk("R9 busy payload no strobe", prog_stb, 0);
    wr(17'h0ABCD, 8'hF0, 1'b1);
    chk("R9 busy F0 no strobe", prog_stb, 0);
    wr(17'h00020, 8'h22, 1'b0);
    chk("R9 program after busy", prog_stb, 1);
    chk("R9 program addr", prog_addr, 17'h00020);
    chk("R9 program data", prog_data, 8'h22);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule